// File: doc/BRIEF.md
# VGA Scanout with SRAM Arbitration

This block produces VGA horizontal and vertical sync at one pixel per clock. It drives an external byte-wide SRAM directly from a running address counter. While the beam is inside the display window, every clock issues a read address, and the byte the SRAM returns goes straight to the colour output. No register or arithmetic sits in that path. Each byte carries two bits each of red, green, blue and shading. The block does not interpret it.

A host loads pixels through a request/acknowledge port. A pending write is granted only on a blanking clock, so display reads are never stalled. Ownership of the SRAM bus is explicit: the read enable is released while the block drives write data, and write data is driven only on a write clock. The upper address bits come from an image-select input and a half-memory input. The image select is taken once per frame, at the frame boundary. The half-memory bit is a static input applied to every access.

Top module: `vga_sram_scan`

## Requirements
- R1: Every line lasts exactly H_ACT+H_FP+H_SYNC+H_BP clocks. `hsync_no` is low exactly on horizontal positions H_ACT+H_FP up to H_ACT+H_FP+H_SYNC-1 and high elsewhere. All outputs lag the position counters by one registered stage.
- R2: Every frame lasts exactly V_ACT+V_FP+V_SYNC+V_BP lines. `vsync_no` is low exactly on lines V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1.
- R3: On each clock of the read window (x < H_ACT and y < V_ACT), `sram_addr_o` = {mem_half_i, image, y*H_ACT+x}, with the pixel index in bits 16:0. On these clocks `sram_oe_no` = 0 and `sram_we_no` = 1. On visible clocks, `pix_o` equals `sram_rdata_i` in the same cycle.
- R4: `pix_o` is 8'h00 outside the read window. It is also 8'h00 on the last column x = H_ACT-1 of every line.
- R5: A host write raised while `wr_ack_o` is low is acknowledged for exactly one clock, on the first blanking clock after the request. On that clock `sram_we_no` = 0, `sram_addr_o` = {mem_half_i, wr_addr_i}, and `sram_wdata_o` = `wr_data_i`.
- R6: No write and no acknowledge occurs on a read-window clock. A pending request has no effect on sync timing or on the read address sequence.
- R7: `sram_wdata_oe_o` is 1 only on write clocks, and `sram_oe_no` is 1 on those clocks. On idle blanking clocks, `sram_oe_no` = 1, `sram_we_no` = 1 and `sram_wdata_oe_o` = 0.
- R8: Address bit 17 on reads is the value of `img_sel_i` captured on the last clock of the previous frame (0 for the first frame after reset). Changes during a frame have no effect until the next frame.
- R9: Address bit 18 of every read and write equals `mem_half_i` in the same registered cycle.
- R10: During reset, `hsync_no` = 1, `vsync_no` = 1, `pix_o` = 0, `wr_ack_o` = 0, `sram_we_no` = 1, `sram_oe_no` = 1 and `sram_wdata_oe_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| img_sel_i | input | 1 | Image to display, taken at the frame boundary (address bit 17) |
| mem_half_i | input | 1 | Static half-memory select (address bit 18) |
| wr_req_i | input | 1 | Host write request, held until acknowledged |
| wr_addr_i | input | IDX_W+1 | Host write address, bits 17:0 |
| wr_data_i | input | PIX_W | Host write byte |
| wr_ack_o | output | 1 | One-clock write acknowledge |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| pix_o | output | PIX_W | Colour byte {shade, blue, green, red} as stored |
| sram_addr_o | output | IDX_W+2 | SRAM address |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM read output enable, active low |
| sram_wdata_o | output | PIX_W | Write data toward the SRAM |
| sram_wdata_oe_o | output | 1 | Write data drive enable; low means released |
| sram_rdata_i | input | PIX_W | Read data from the SRAM |

## Verification
The bench raises write requests at random points, including two clocks before the end of an active line. A design that granted too early would corrupt a read address. One that acknowledged twice, or waited past the first blanking clock, shows up as an acknowledge mismatch. The last visible column and the blanking clocks check the black forcing; an off-by-one window leaks a stored byte onto the edge. The image select is toggled mid-frame, and a design that took it immediately would issue the wrong bit 17 on the rest of that frame. The half-memory bit is flipped to catch a stale or missing bit 18 on reads and writes.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_own_e;
endpackage

// File: rtl/vga_scan_timing.sv
module vga_scan_timing #(
  parameter int H_ACT  = 320,
  parameter int H_FP   = 8,
  parameter int H_SYNC = 48,
  parameter int H_BP   = 24,
  parameter int V_ACT  = 240,
  parameter int V_FP   = 3,
  parameter int V_SYNC = 3,
  parameter int V_BP   = 16,
  parameter int HW     = $clog2(H_ACT + H_FP + H_SYNC + H_BP),
  parameter int VW     = $clog2(V_ACT + V_FP + V_SYNC + V_BP)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic line_end_o,
  output logic frame_end_o,
  output logic read_win_o,
  output logic vis_o,
  output logic hs_n_o,
  output logic vs_n_o
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_ACT_C = HW'(H_ACT);
  localparam logic [HW-1:0] H_VIS_C = HW'(H_ACT - 1);
  localparam logic [HW-1:0] H_SS = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] H_SE = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_ACT_C = VW'(V_ACT);
  localparam logic [VW-1:0] V_SS = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] V_SE = VW'(V_ACT + V_FP + V_SYNC);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  assign line_end_o  = (h_q == H_LAST);
  assign frame_end_o = line_end_o && (v_q == V_LAST);
  assign read_win_o  = (h_q < H_ACT_C) && (v_q < V_ACT_C);
  assign vis_o       = (h_q < H_VIS_C) && (v_q < V_ACT_C);
  assign hs_n_o      = !((h_q >= H_SS) && (h_q < H_SE));
  assign vs_n_o      = !((v_q >= V_SS) && (v_q < V_SE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= line_end_o ? '0 : h_q + HW'(1);
      if (line_end_o) v_q <= (v_q == V_LAST) ? '0 : v_q + VW'(1);
    end
  end

  // fixed line length: wrap only from the last position, otherwise step by one
  assert_line_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |=> (h_q == '0));
  assert_line_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_o |=> (h_q == $past(h_q) + HW'(1)));
  assert_line_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_o |=> $stable(v_q));
endmodule

// File: rtl/vga_scan_addr.sv
module vga_scan_addr #(
  parameter int IDX_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_win_i,
  input  logic             frame_end_i,
  input  logic             img_sel_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             img_o
);
  logic [IDX_W-1:0] idx_q;
  logic             img_q;

  assign idx_o = idx_q;
  assign img_o = img_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      img_q <= 1'b0;
    end else begin
      if (frame_end_i) begin
        idx_q <= '0;
        img_q <= img_sel_i;
      end else if (read_win_i) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assert_img_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(img_q));
  assert_idx_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (idx_q == '0));
  assert_idx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!read_win_i && !frame_end_i) |=> $stable(idx_q));
endmodule

// File: rtl/vga_scan_wr_arb.sv
module vga_scan_wr_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic blank_i,
  output logic grant_o,
  output logic ack_o
);
  logic ack_q;

  // a request still high on the clock after its acknowledge is not granted again
  assign grant_o = req_i && blank_i && !ack_q;
  assign ack_o   = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= grant_o;
  end

  assert_ack_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  assert_ack_in_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(blank_i));
  assert_ack_follows_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(req_i));
endmodule

// File: rtl/vga_sram_scan.sv
module vga_sram_scan
  import vga_scan_pkg::*;
#(
  parameter int H_ACT  = 320,
  parameter int H_FP   = 8,
  parameter int H_SYNC = 48,
  parameter int H_BP   = 24,
  parameter int V_ACT  = 240,
  parameter int V_FP   = 3,
  parameter int V_SYNC = 3,
  parameter int V_BP   = 16,
  parameter int IDX_W  = 17,
  parameter int PIX_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               img_sel_i,
  input  logic               mem_half_i,
  input  logic               wr_req_i,
  input  logic [IDX_W:0]     wr_addr_i,
  input  logic [PIX_W-1:0]   wr_data_i,
  output logic               wr_ack_o,
  output logic               hsync_no,
  output logic               vsync_no,
  output logic [PIX_W-1:0]   pix_o,
  output logic [IDX_W+1:0]   sram_addr_o,
  output logic               sram_we_no,
  output logic               sram_oe_no,
  output logic [PIX_W-1:0]   sram_wdata_o,
  output logic               sram_wdata_oe_o,
  input  logic [PIX_W-1:0]   sram_rdata_i
);
  localparam int AW = IDX_W + 2;
  localparam int HW = $clog2(H_ACT + H_FP + H_SYNC + H_BP);
  localparam int VW = $clog2(V_ACT + V_FP + V_SYNC + V_BP);

  logic             line_end, frame_end, read_win, vis, hs_n, vs_n;
  logic [IDX_W-1:0] idx;
  logic             disp_img;
  logic             grant;

  vga_scan_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .line_end_o(line_end), .frame_end_o(frame_end),
    .read_win_o(read_win), .vis_o(vis),
    .hs_n_o(hs_n), .vs_n_o(vs_n)
  );

  vga_scan_addr #(.IDX_W(IDX_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .read_win_i(read_win), .frame_end_i(frame_end),
    .img_sel_i(img_sel_i),
    .idx_o(idx), .img_o(disp_img)
  );

  vga_scan_wr_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(wr_req_i), .blank_i(!read_win),
    .grant_o(grant), .ack_o(wr_ack_o)
  );

  // single output stage: syncs, bus owner and address leave together
  logic              hs_q, vs_q, vis_q;
  logic [AW-1:0]     addr_q;
  logic [PIX_W-1:0]  wdata_q;
  bus_own_e          own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q    <= 1'b1;
      vs_q    <= 1'b1;
      vis_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      own_q   <= BUS_IDLE;
    end else begin
      hs_q  <= hs_n;
      vs_q  <= vs_n;
      vis_q <= vis;
      if (grant) begin
        own_q   <= BUS_WRITE;
        addr_q  <= {mem_half_i, wr_addr_i};
        wdata_q <= wr_data_i;
      end else if (read_win) begin
        own_q  <= BUS_READ;
        addr_q <= {mem_half_i, disp_img, idx};
      end else begin
        own_q <= BUS_IDLE;
      end
    end
  end

  assign hsync_no        = hs_q;
  assign vsync_no        = vs_q;
  assign sram_addr_o     = addr_q;
  assign sram_wdata_o    = wdata_q;
  assign sram_we_no      = (own_q != BUS_WRITE);
  assign sram_oe_no      = (own_q != BUS_READ);
  assign sram_wdata_oe_o = (own_q == BUS_WRITE);
  assign pix_o           = vis_q ? sram_rdata_i : '0;

  assert_bus_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_wdata_oe_o |-> sram_oe_no);
  assert_write_black_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (pix_o == '0));
  assert_sync_black_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> (pix_o == '0));
  assert_ack_is_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> !sram_we_no);
  assert_half_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no || !sram_oe_no) |-> (sram_addr_o[AW-1] == $past(mem_half_i)));
endmodule

// File: tb/vga_sram_scan_tb.sv
module vga_sram_scan_tb_top;
  localparam int H_ACT = 16, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_ACT = 6, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int IDX_W = 17;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        img_sel_i = 1'b0;
  logic        mem_half_i = 1'b0;
  logic        wr_req_i = 1'b0;
  logic [17:0] wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        wr_ack_o, hsync_no, vsync_no, sram_we_no, sram_oe_no, sram_wdata_oe_o;
  logic [7:0]  pix_o, sram_wdata_o, sram_rdata_i;
  logic [18:0] sram_addr_o;

  always #2 clk_i = ~clk_i;

  logic [7:0] mem [4096];

  function automatic int sidx(input logic [18:0] a);
    return int'({a[18:17], a[9:0]});
  endfunction

  assign sram_rdata_i = mem[sidx(sram_addr_o)];

  vga_sram_scan #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .IDX_W(IDX_W), .PIX_W(8)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .img_sel_i(img_sel_i), .mem_half_i(mem_half_i),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_ack_o(wr_ack_o),
    .hsync_no(hsync_no), .vsync_no(vsync_no), .pix_o(pix_o), .sram_addr_o(sram_addr_o),
    .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no), .sram_wdata_o(sram_wdata_o),
    .sram_wdata_oe_o(sram_wdata_oe_o), .sram_rdata_i(sram_rdata_i)
  );

  int  checks = 0;
  int  errors = 0;
  int  n = -1;
  bit  req_pend = 1'b0;
  bit  just_done = 1'b0;
  bit  exp_img = 1'b0;
  bit  finished = 1'b0;
  int  writes_done = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h (n=%0d)", r, act, exp, n);
    end
  endtask

  task automatic check_cycle();
    int x = n % H_TOT;
    int y = (n / H_TOT) % V_TOT;
    bit rw = (x < H_ACT) && (y < V_ACT);
    bit vis = (x < H_ACT - 1) && (y < V_ACT);
    bit exp_hs = !((x >= H_ACT + H_FP) && (x < H_ACT + H_FP + H_SYNC));
    bit exp_vs = !((y >= V_ACT + V_FP) && (y < V_ACT + V_FP + V_SYNC));
    logic [18:0] ea;
    just_done = 1'b0;
    chk(hsync_no == exp_hs, "R1 hsync", hsync_no, exp_hs);
    chk(vsync_no == exp_vs, "R2 vsync", vsync_no, exp_vs);
    if (rw) begin
      ea = {mem_half_i, exp_img, IDX_W'(y * H_ACT + x)};
      chk(sram_addr_o == ea, "R3/R8/R9 read addr", sram_addr_o, ea);
      chk(!sram_oe_no && sram_we_no && !sram_wdata_oe_o, "R3 read strobes",
          {sram_oe_no, sram_we_no, sram_wdata_oe_o}, 3'b010);
      chk(!wr_ack_o, "R6 no ack in read window", wr_ack_o, 0);
      if (vis) chk(pix_o == mem[sidx(ea)], "R3 pixel", pix_o, mem[sidx(ea)]);
      else     chk(pix_o == 8'h00, "R4 last column black", pix_o, 0);
    end else begin
      chk(pix_o == 8'h00, "R4 blank black", pix_o, 0);
      if (req_pend) begin
        ea = {mem_half_i, wr_addr_i};
        chk(wr_ack_o, "R5 ack on first blank", wr_ack_o, 1);
        chk(!sram_we_no, "R5 write strobe", sram_we_no, 0);
        chk(sram_addr_o == ea, "R5/R9 write addr", sram_addr_o, ea);
        chk(sram_wdata_o == wr_data_i, "R5 write data", sram_wdata_o, wr_data_i);
        chk(sram_wdata_oe_o && sram_oe_no, "R7 write owns bus",
            {sram_wdata_oe_o, sram_oe_no}, 2'b11);
        mem[sidx(ea)] = wr_data_i;
        writes_done++;
        req_pend = 1'b0;
        just_done = 1'b1;
        wr_req_i = 1'b0;
      end else begin
        chk(!wr_ack_o, "R5 no spurious ack", wr_ack_o, 0);
        chk(sram_we_no && sram_oe_no && !sram_wdata_oe_o, "R7 idle bus released",
            {sram_we_no, sram_oe_no, sram_wdata_oe_o}, 3'b110);
      end
    end
    if (n % FRAME == FRAME - 1) exp_img = img_sel_i;
  endtask

  task automatic launch(input bit bank, input int rate);
    if (!req_pend && !just_done && ($urandom_range(0, rate - 1) == 0)) begin
      wr_addr_i = {bank, 7'd0, 10'($urandom_range(0, H_ACT * V_ACT - 1))};
      wr_data_i = 8'($urandom);
      wr_req_i  = 1'b1;
      req_pend  = 1'b1;
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    n++;
    check_cycle();
  endtask

  task automatic run(input int cycles, input bit bank, input int rate);
    for (int i = 0; i < cycles; i++) begin
      tick();
      launch(bank, rate);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=%0d exp=done", n);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    // R10 reset state
    repeat (3) @(negedge clk_i);
    chk(hsync_no && vsync_no, "R10 syncs idle high", {hsync_no, vsync_no}, 2'b11);
    chk(pix_o == 8'h00, "R10 pixel black", pix_o, 0);
    chk(!wr_ack_o, "R10 no ack", wr_ack_o, 0);
    chk(sram_we_no && sram_oe_no && !sram_wdata_oe_o, "R10 bus released",
        {sram_we_no, sram_oe_no, sram_wdata_oe_o}, 3'b110);
    rst_ni = 1'b1;

    // image 0 on display, random writes into image 1
    run(2 * FRAME, 1'b1, 6);
    // directed: request two clocks before the end of an active line
    while (req_pend || just_done) tick();
    while (!((n + 1) % H_TOT == H_ACT - 3 && ((n + 1) / H_TOT) % V_TOT == 1)) tick();
    wr_addr_i = {1'b1, 7'd0, 10'd5};
    wr_data_i = 8'hA5;
    wr_req_i  = 1'b1;
    req_pend  = 1'b1;
    run(H_TOT, 1'b1, 1000000);

    // R8: toggle select mid-frame, settle on image 1
    while ((n + 1) % FRAME != FRAME / 3) tick();
    img_sel_i = 1'b1;
    run(20, 1'b1, 4);
    img_sel_i = 1'b0;
    run(7, 1'b1, 4);
    img_sel_i = 1'b1;
    run(2 * FRAME, 1'b1, 5);

    // R9: upper half of memory, writes continue
    mem_half_i = 1'b1;
    run(2 * FRAME, 1'b0, 5);
    img_sel_i = 1'b0;
    run(2 * FRAME, 1'b1, 3);
    while (req_pend) tick();
    run(4, 1'b0, 1000000);

    chk(writes_done > 20, "R5 writes completed", writes_done, 21);
    finish_run();
  end
endmodule